// File: doc/BRIEF.md
# Power Switch Overcurrent Timer and Fault Recovery Controller

This block decides when the output power switch of a single network power port may conduct, and how the port comes back after a fault. It watches two inputs. The first is a flag that is high while the analog current limiter is regulating. The second is an overtemperature flag whose hysteresis is handled outside the block. A synchronous one-millisecond tick paces every time window. The block drives the switch enable and an active-low fault indication. It also issues one-cycle restart requests, either to the detection sequencer or straight to the power-up stage.

A fault occurs when the limiter stays active for 60 consecutive ticks, or when overtemperature is reported while the switch conducts. The switch opens and the fault indication latches. The block then waits until every fault cause has cleared and counts a 1920-tick restart delay. What happens after the delay depends on the recovery mode. In auto-retry mode the block requests a restart by itself. In latch-off mode it stays off until the enable input goes low and then high again. An enable rising edge seen during the delay is remembered and honoured when the delay ends. The enable input going low stops the port.

The controller has seven states:

| State | Meaning |
|---|---|
| IDLE | Port disabled. |
| REQUEST | One cycle in which a restart request is issued. |
| AWAIT | Waiting for the detection sequencer to grant power. |
| POWER | The switch conducts. |
| FAULTED | The switch is off and the block is waiting for every fault cause to clear. |
| WAIT | The restart delay is being counted. |
| LATCHED | Latch-off hold; the block waits for the enable input to go low. |

The transitions are:

- IDLE→REQUEST when the enable input is high.
- REQUEST→POWER when detection is skipped.
- REQUEST→AWAIT when detection is used.
- AWAIT→POWER when the grant arrives.
- REQUEST, AWAIT or POWER→IDLE when the enable input is low.
- POWER→FAULTED on an overcurrent timeout or on overtemperature.
- FAULTED→WAIT once neither fault cause is present.
- WAIT→REQUEST, WAIT→LATCHED or WAIT→IDLE when the delay ends.
- LATCHED→IDLE when the enable input is low.

Top module: `swpwr_fault_ctrl`

## Requirements
- R1: While `ilim_active` is high in POWER, a count advances on each cycle where `tick_ms` is high. The count clears whenever `ilim_active` is low. Bursts of fewer than 60 ticks, repeated any number of times with the limit released between them, never cause a fault.
- R2: On the clock edge that samples the 60th consecutive tick with `ilim_active` high, `sw_on` goes to 0 and `fault_n` goes to 0.
- R3: If `overtemp` is high while `sw_on` is 1, then `sw_on` is 0 and `fault_n` is 0 after the next clock edge.
- R4: The restart delay starts only on the clock edge after both `overtemp` and `ilim_active` are low. No restart request appears while either of them stays high. Once started, the delay ends on its 1920th tick.
- R5: In auto-retry mode (`latch_off` = 0) with `en` high, the delay end produces a single-cycle request. That request is `req_detect` when `skip_detect` is 0 and `req_powerup` when `skip_detect` is 1.
- R6: In latch-off mode (`latch_off` = 1), the switch stays off after the delay ends until `en` goes low and then high. A rising edge of `en` seen during FAULTED or WAIT is held, and it causes the request when the delay ends.
- R7: `fault_n` stays 0 from the fault until the clock edge on which `sw_on` next rises, and it rises on that same edge. It is never 0 while `sw_on` is 1.
- R8: After a clock edge that samples `en` low, `sw_on` is 0. `en` low in LATCHED returns the block to IDLE and clears the latch-off.
- R9: With `en` high in IDLE, a request is asserted on the next edge. With `skip_detect` = 1, `sw_on` rises on the edge after `req_powerup`. With `skip_detect` = 0, `sw_on` rises on the edge after `pwr_grant` is sampled high in AWAIT.
- R10: After reset, `sw_on`, `req_detect` and `req_powerup` are 0 and `fault_n` is 1.
- R11: An overcurrent timeout and overtemperature on the same edge give a single fault entry, followed by one restart delay of exactly 1920 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| ilim_active | input | 1 | Current limiter is regulating |
| overtemp | input | 1 | Die overtemperature flag |
| en | input | 1 | Port enable |
| latch_off | input | 1 | 1 = latch-off recovery, 0 = auto-retry |
| skip_detect | input | 1 | 1 = restart straight to power-up |
| pwr_grant | input | 1 | Sequencer finished detection; power may start |
| sw_on | output | 1 | Power switch enable |
| fault_n | output | 1 | Latched fault indication, active low |
| req_detect | output | 1 | One-cycle request to start detection |
| req_powerup | output | 1 | One-cycle request for direct power-up |

## Verification
The vector table probes the overcurrent window at 59, 60 and 70 ticks, and with repeated sub-limit bursts. A timer that did not clear on release would trip on the bursts, and an off-by-one would trip at 59 or miss 60.

Directed tests hold a fault cause high well past the delay length. A design that starts the delay too early would request a restart while the cause is still present. The exact 1919/1920-tick boundary catches a delay of the wrong length.

The latch-off tests cover three cases:
- `en` held high, where a wrong design would restart by itself.
- `en` toggled during the delay, where a design that drops the edge would stay latched.
- `en` toggled after latching.

A coincident overtemperature and overcurrent trip must give exactly one delay, not two.

// File: rtl/swpwr_pkg.sv
package swpwr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_AWAIT,
        ST_POWER,
        ST_FAULTED,
        ST_WAIT,
        ST_LATCHED
    } fm_state_e;
endpackage

// File: rtl/swpwr_tick_window.sv
// Counts ticks while run is high. done pulses on the LEN-th counted tick.
// The count clears whenever run is low.
module swpwr_tick_window #(
    parameter int LEN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = (LEN > 1) ? $clog2(LEN + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && tick && (cnt_q == LAST);
endmodule

// File: rtl/swpwr_en_edge.sv
// Detects a rising edge of en and holds it while hold is high.
module swpwr_en_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hold,
    output logic rise_seen
);
    logic en_q;
    logic held_q;
    logic rise;

    assign rise = en && !en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            held_q <= 1'b0;
        end else begin
            en_q <= en;
            if (!hold) begin
                held_q <= 1'b0;
            end else if (rise) begin
                held_q <= 1'b1;
            end
        end
    end

    assign rise_seen = held_q || (hold && rise);
endmodule

// File: rtl/swpwr_fault_ctrl.sv
module swpwr_fault_ctrl
    import swpwr_pkg::*;
#(
    parameter int OC_LIMIT_TICKS = 60,
    parameter int RESTART_TICKS  = 1920
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic ilim_active,
    input  logic overtemp,
    input  logic en,
    input  logic latch_off,
    input  logic skip_detect,
    input  logic pwr_grant,
    output logic sw_on,
    output logic fault_n,
    output logic req_detect,
    output logic req_powerup
);
    fm_state_e state_q;
    fm_state_e state_d;
    logic      oc_run;
    logic      oc_expired;
    logic      wait_run;
    logic      wait_done;
    logic      edge_hold;
    logic      en_rise_seen;
    logic      fault_q;

    assign oc_run    = (state_q == ST_POWER) && ilim_active;
    assign wait_run  = (state_q == ST_WAIT);
    assign edge_hold = (state_q == ST_FAULTED) || (state_q == ST_WAIT);

    swpwr_tick_window #(.LEN(OC_LIMIT_TICKS)) u_oc_window (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (oc_run),
        .tick (tick_ms),
        .done (oc_expired)
    );

    swpwr_tick_window #(.LEN(RESTART_TICKS)) u_restart_window (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (wait_run),
        .tick (tick_ms),
        .done (wait_done)
    );

    swpwr_en_edge u_en_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .hold     (edge_hold),
        .rise_seen(en_rise_seen)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en) state_d = ST_REQUEST;
            end
            ST_REQUEST: begin
                if (!en)              state_d = ST_IDLE;
                else if (skip_detect) state_d = ST_POWER;
                else                  state_d = ST_AWAIT;
            end
            ST_AWAIT: begin
                if (!en)            state_d = ST_IDLE;
                else if (pwr_grant) state_d = ST_POWER;
            end
            ST_POWER: begin
                if (oc_expired || overtemp) state_d = ST_FAULTED;
                else if (!en)               state_d = ST_IDLE;
            end
            ST_FAULTED: begin
                if (!overtemp && !ilim_active) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (wait_done) begin
                    if (!en)                            state_d = ST_IDLE;
                    else if (!latch_off || en_rise_seen) state_d = ST_REQUEST;
                    else                                state_d = ST_LATCHED;
                end
            end
            ST_LATCHED: begin
                if (!en) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic: the fault latch is set on fault entry and cleared on power entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if ((state_q == ST_POWER) && (state_d == ST_FAULTED)) begin
            fault_q <= 1'b1;
        end else if ((state_q != ST_POWER) && (state_d == ST_POWER)) begin
            fault_q <= 1'b0;
        end
    end

    assign sw_on       = (state_q == ST_POWER);
    assign fault_n     = !fault_q;
    assign req_detect  = (state_q == ST_REQUEST) && !skip_detect;
    assign req_powerup = (state_q == ST_REQUEST) && skip_detect;
endmodule

// File: rtl/swpwr_fault_chk.sv
module swpwr_fault_chk #(
    parameter int OC_LIMIT_TICKS = 60
) (
    input logic clk,
    input logic rst_n,
    input logic tick_ms,
    input logic ilim_active,
    input logic overtemp,
    input logic en,
    input logic sw_on,
    input logic fault_n,
    input logic req_detect,
    input logic req_powerup
);
    localparam int CW = $clog2(OC_LIMIT_TICKS + 2);

    logic [CW-1:0] lim_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_ticks <= '0;
        end else if (!sw_on || !ilim_active) begin
            lim_ticks <= '0;
        end else if (tick_ms) begin
            lim_ticks <= lim_ticks + 1'b1;
        end
    end

    p_oc_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_on |-> (lim_ticks < CW'(OC_LIMIT_TICKS)));

    p_ot_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_on && overtemp) |=> (!sw_on && !fault_n));

    p_fault_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_on && !fault_n));

    p_fault_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n) |-> $rose(sw_on));

    p_en_low_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sw_on);

    p_req_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_detect, req_powerup, sw_on}));

    p_powerup_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_powerup && en) |=> sw_on);
endmodule

bind swpwr_fault_ctrl swpwr_fault_chk #(.OC_LIMIT_TICKS(OC_LIMIT_TICKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_ms    (tick_ms),
    .ilim_active(ilim_active),
    .overtemp   (overtemp),
    .en         (en),
    .sw_on      (sw_on),
    .fault_n    (fault_n),
    .req_detect (req_detect),
    .req_powerup(req_powerup)
);

// File: tb/tb_swpwr_fault_ctrl.sv
`timescale 1ns/1ps
module tb_swpwr_fault_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0;
    logic ilim_active = 1'b0;
    logic overtemp = 1'b0;
    logic en = 1'b0;
    logic latch_off = 1'b0;
    logic skip_detect = 1'b1;
    logic pwr_grant = 1'b0;
    logic sw_on, fault_n, req_detect, req_powerup;

    int n_checks = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    swpwr_fault_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .ilim_active(ilim_active),
        .overtemp(overtemp), .en(en), .latch_off(latch_off), .skip_detect(skip_detect),
        .pwr_grant(pwr_grant), .sw_on(sw_on), .fault_n(fault_n),
        .req_detect(req_detect), .req_powerup(req_powerup)
    );

    // Tick: high for one cycle out of every four, changed at the falling edge
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div == 3) ? 0 : div + 1;
            tick_ms = (div == 0);
        end
    end

    // Vector table: {bursts[3:0], ticks per burst[7:0], 3'b0, fault expected}
    localparam int NVEC = 6;
    localparam logic [15:0] OC_VEC [NVEC] = '{
        {4'd1, 8'd1,  3'd0, 1'b0},
        {4'd1, 8'd59, 3'd0, 1'b0},
        {4'd1, 8'd60, 3'd0, 1'b1},
        {4'd3, 8'd59, 3'd0, 1'b0},
        {4'd2, 8'd30, 3'd0, 1'b0},
        {4'd1, 8'd70, 3'd0, 1'b1}
    };

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic wait_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick_ms) @(posedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0; ilim_active = 1'b0; overtemp = 1'b0;
        pwr_grant = 1'b0; latch_off = 1'b0; skip_detect = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // From IDLE with skip_detect high: REQUEST after one edge, POWER after two
    task automatic power_up();
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic poll_req(int max_cycles, output bit seen_det, output bit seen_pu);
        seen_det = 1'b0; seen_pu = 1'b0;
        for (int i = 0; i < max_cycles; i++) begin
            @(negedge clk);
            if (req_detect)  seen_det = 1'b1;
            if (req_powerup) seen_pu = 1'b1;
            if (seen_det || seen_pu) break;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        bit sd, sp;

        // R10: reset state
        do_reset();
        check("R10 sw_on", int'(sw_on), 0);
        check("R10 fault_n", int'(fault_n), 1);
        check("R10 requests", int'(req_detect | req_powerup), 0);

        // R1 / R2: overcurrent window vectors
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            power_up();
            check("R9 powered", int'(sw_on), 1);
            for (int b = 0; b < int'(OC_VEC[v][15:12]); b++) begin
                @(negedge clk);
                ilim_active = 1'b1;
                wait_ticks(int'(OC_VEC[v][11:4]));
                @(negedge clk);
                ilim_active = 1'b0;
                repeat (2) @(negedge clk);
            end
            check(OC_VEC[v][0] ? "R2 fault_n" : "R1 fault_n", int'(fault_n), OC_VEC[v][0] ? 0 : 1);
            check(OC_VEC[v][0] ? "R2 sw_on" : "R1 sw_on", int'(sw_on), OC_VEC[v][0] ? 0 : 1);
        end

        // R2: exact edge of the 60th tick
        do_reset();
        power_up();
        @(negedge clk);
        ilim_active = 1'b1;
        wait_ticks(59);
        @(negedge clk);
        check("R2 on after 59", int'(sw_on), 1);
        wait_ticks(1);
        @(negedge clk);
        check("R2 off at 60", int'(sw_on), 0);
        check("R2 fault at 60", int'(fault_n), 0);

        // R8: en low while powered
        do_reset();
        power_up();
        en = 1'b0;
        @(negedge clk);
        check("R8 en low off", int'(sw_on), 0);
        check("R8 no fault", int'(fault_n), 1);

        // R9: detection path waits for the grant
        do_reset();
        skip_detect = 1'b0;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        check("R9 req_detect", int'(req_detect), 1);
        repeat (5) @(negedge clk);
        check("R9 waits for grant", int'(sw_on), 0);
        pwr_grant = 1'b1;
        @(negedge clk);
        pwr_grant = 1'b0;
        check("R9 granted", int'(sw_on), 1);

        // R3 / R4 / R5 / R7: overtemp trip, delay starts after cooling, auto retry
        do_reset();
        power_up();
        overtemp = 1'b1;
        @(negedge clk);
        check("R3 off", int'(sw_on), 0);
        check("R3 fault", int'(fault_n), 0);
        wait_ticks(2100);
        @(negedge clk);
        check("R4 no restart while hot", int'(req_detect | req_powerup | sw_on), 0);
        overtemp = 1'b0;
        @(posedge clk);
        wait_ticks(1919);
        @(negedge clk);
        check("R4 no request at 1919", int'(req_powerup), 0);
        wait_ticks(1);
        @(negedge clk);
        check("R5 req_powerup at 1920", int'(req_powerup), 1);
        check("R7 fault held in request", int'(fault_n), 0);
        @(negedge clk);
        check("R7 on", int'(sw_on), 1);
        check("R7 cleared at power", int'(fault_n), 1);

        // R5: auto retry into detection
        do_reset();
        power_up();
        skip_detect = 1'b0;
        overtemp = 1'b1;
        @(negedge clk);
        overtemp = 1'b0;
        poll_req(1920 * 4 + 40, sd, sp);
        check("R5 req_detect", int'(sd), 1);
        check("R5 no req_powerup", int'(sp), 0);

        // R11 / R4: coincident trip, limiter held high after the trip
        do_reset();
        power_up();
        ilim_active = 1'b1;
        wait_ticks(59);
        @(negedge clk);
        #1;
        while (!tick_ms) begin
            @(negedge clk);
            #1;
        end
        overtemp = 1'b1;
        @(negedge clk);
        check("R11 off", int'(sw_on), 0);
        check("R11 fault", int'(fault_n), 0);
        overtemp = 1'b0;
        wait_ticks(2100);
        @(negedge clk);
        check("R4 no restart while limiting", int'(req_detect | req_powerup | sw_on), 0);
        ilim_active = 1'b0;
        @(posedge clk);
        wait_ticks(1919);
        @(negedge clk);
        check("R11 single delay 1919", int'(req_powerup), 0);
        wait_ticks(1);
        @(negedge clk);
        check("R11 single delay 1920", int'(req_powerup), 1);

        // R6: latch-off with en held high stays off, then en toggle restarts
        do_reset();
        latch_off = 1'b1;
        power_up();
        ilim_active = 1'b1;
        wait_ticks(60);
        @(negedge clk);
        ilim_active = 1'b0;
        wait_ticks(1970);
        @(negedge clk);
        check("R6 latched off", int'(sw_on | req_powerup | req_detect), 0);
        check("R6 fault held", int'(fault_n), 0);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        check("R8 latch cleared request", int'(req_powerup), 1);
        @(negedge clk);
        check("R6 on after toggle", int'(sw_on), 1);

        // R6: en toggled during the delay is held
        do_reset();
        latch_off = 1'b1;
        power_up();
        overtemp = 1'b1;
        @(negedge clk);
        overtemp = 1'b0;
        wait_ticks(100);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        check("R6 no early restart", int'(sw_on | req_powerup), 0);
        poll_req(1920 * 4, sd, sp);
        check("R6 held edge restarts", int'(sp), 1);

        finish_run();
    end
endmodule